// File: doc/BRIEF.md
# Masked Bit Merge Unit

This unit combines two data words under a bit mask and registers the result. It reads three operands: the destination word, the source word, and a third operand that holds either a mask or a bit count. For each bit position, the mask decides which of the two data words supplies that bit. The result is meant to replace the destination word. A field insert that would otherwise take several logical instructions therefore becomes a single operation.

A two-bit operation code selects one of four behaviours:

- Plain merge uses the third operand directly as the mask.
- Splice treats the third operand as a count `n`. It builds a mask that covers the low `n` bits.
- Inverted merge swaps the roles of the two data words.
- The fourth code is reserved and returns the destination unchanged.

The result and its valid flag appear one clock after the input strobe. The result holds its value until the next strobe.

Top module: `bmu_merge_unit`

## Requirements
- R1: With op code 2'b00 (merge), each result bit equals the source bit where the mask operand bit is 1, and equals the destination bit where it is 0.
- R2: With op code 2'b01 (splice) and a count `n` between 1 and 31 held as an unsigned value in the mask operand, result bits [n-1:0] come from the source and bits [31:n] come from the destination.
- R3: A splice count of 0 returns the destination unchanged. A splice count of 32 or more, compared as an unsigned value, returns the whole source.
- R4: With op code 2'b10 (inverted merge), each result bit equals the destination bit where the mask bit is 1, and equals the source bit where it is 0.
- R5: Op code 2'b11 is reserved and returns the destination unchanged, whatever the source and mask are.
- R6: The result for inputs accepted with `in_valid` high appears on `res` after the next rising clock edge. `out_valid` equals `in_valid` delayed by one cycle.
- R7: While `in_valid` is low, `res` keeps its previous value, whatever is on the data inputs.
- R8: A synchronous active-high reset clears `res` to 0 and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| op | input | 2 | Operation code: 00 merge, 01 splice, 10 inverted merge, 11 reserved |
| dst | input | 32 | Destination word |
| src | input | 32 | Source word |
| msk | input | 32 | Mask, or unsigned splice count |
| res | output | 32 | Registered merged result |
| out_valid | output | 1 | Result valid, one cycle after in_valid |

## Verification
The merge operation is driven with these masks:

- An all-zero mask, which shows whether the destination is passed through untouched.
- An all-ones mask, which shows whether the source is passed through untouched.
- A mid-word field mask with mixed data, which exposes swapped or inverted operand roles.

Splice is driven with these counts:

- 0, 1, 7 and 16, covering the low end and a mid-word field.
- 31, just below full width.
- 32 and 0xFFFFFFFF, both at or beyond full width.

These counts separate an off-by-one mask boundary from a truncated count compare. The same field mask is applied in inverted and plain form, so a polarity mix-up shows. Idle cycles with changed inputs confirm that the result is held.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [1:0] {
    OP_MERGE  = 2'b00,
    OP_SPLICE = 2'b01,
    OP_INVMRG = 2'b10,
    OP_RSVD   = 2'b11
  } bmu_op_e;
endpackage

// File: rtl/bmu_mask_gen.sv
module bmu_mask_gen #(
  parameter int DATA_W = 32
) (
  input  logic              use_count,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] mask
);
  logic [DATA_W-1:0] low_field;

  // Bit i is set when the unsigned count exceeds i; counts >= DATA_W saturate.
  for (genvar i = 0; i < DATA_W; i++) begin : g_field
    assign low_field[i] = (operand > DATA_W'(i));
  end

  assign mask = use_count ? low_field : operand;
endmodule

// File: rtl/bmu_merge_core.sv
module bmu_merge_core
  import bmu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  bmu_op_e           op,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] merged
);
  always_comb begin
    unique case (op)
      OP_MERGE, OP_SPLICE: merged = (dst & ~mask) | (src & mask);
      OP_INVMRG:           merged = (dst & mask) | (src & ~mask);
      default:             merged = dst;
    endcase
  end
endmodule

// File: rtl/bmu_merge_unit.sv
module bmu_merge_unit
  import bmu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] msk,
  output logic [DATA_W-1:0] res,
  output logic              out_valid
);
  bmu_op_e           op_q;
  logic [DATA_W-1:0] mask_w;
  logic [DATA_W-1:0] merged_w;

  assign op_q = bmu_op_e'(op);

  bmu_mask_gen #(.DATA_W(DATA_W)) u_mask (
    .use_count (op_q == OP_SPLICE),
    .operand   (msk),
    .mask      (mask_w)
  );

  bmu_merge_core #(.DATA_W(DATA_W)) u_core (
    .op     (op_q),
    .dst    (dst),
    .src    (src),
    .mask   (mask_w),
    .merged (merged_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) res <= merged_w;
    end
  end
endmodule

// File: rtl/bmu_merge_chk.sv
module bmu_merge_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        op,
  input logic [DATA_W-1:0] dst,
  input logic [DATA_W-1:0] src,
  input logic [DATA_W-1:0] msk,
  input logic [DATA_W-1:0] res,
  input logic              out_valid
);
  // R1
  merge_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b00) |=> res == (($past(dst) & ~$past(msk)) | ($past(src) & $past(msk))));

  // R3
  splice_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b01 && msk == '0) |=> res == $past(dst));

  // R3
  splice_full_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b01 && msk >= DATA_W) |=> res == $past(src));

  // R4
  inv_merge_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b10) |=> res == (($past(dst) & $past(msk)) | ($past(src) & ~$past(msk))));

  // R5
  reserved_op_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b11) |=> res == $past(dst));

  // R6
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res) && !out_valid));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (res == '0 && !out_valid));
endmodule

bind bmu_merge_unit bmu_merge_chk #(.DATA_W(DATA_W)) u_bmu_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op        (op),
  .dst       (dst),
  .src       (src),
  .msk       (msk),
  .res       (res),
  .out_valid (out_valid)
);

// File: tb/bmu_merge_unit_bench.sv
`timescale 1ns/1ps
module bmu_merge_unit_bench;
  localparam int W  = 32;
  localparam int NV = 13;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [1:0]   op;
  logic [W-1:0] dst, src, msk;
  logic [W-1:0] res;
  logic         out_valid;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  bmu_merge_unit #(.DATA_W(W)) u_bmu_merge_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .dst(dst), .src(src), .msk(msk), .res(res), .out_valid(out_valid)
  );

  localparam logic [1:0] V_OP [NV] = '{
    2'b00, 2'b01, 2'b00, 2'b00, 2'b01, 2'b01, 2'b01,
    2'b01, 2'b01, 2'b10, 2'b10, 2'b11, 2'b01};
  localparam logic [W-1:0] V_MSK [NV] = '{
    32'h0007FF00, 32'd7, 32'h0, 32'hFFFFFFFF, 32'd0, 32'd32, 32'hFFFFFFFF,
    32'd16, 32'd31, 32'h0007FF00, 32'hFFFF0000, 32'hFFFFFFFF, 32'd1};
  localparam logic [W-1:0] V_SRC [NV] = '{
    32'hC5680CB2, 32'h0, 32'hFFFFFFFF, 32'hA5A5A5A5, 32'hFFFFFFFF, 32'hCAFEBABE, 32'h12345678,
    32'hDEADBEEF, 32'h0, 32'hC5680CB2, 32'h11111111, 32'hFFFFFFFF, 32'h00000001};
  localparam logic [W-1:0] V_DST [NV] = '{
    32'h1AF7C1E8, 32'hFFFFFFFF, 32'h12345678, 32'h0, 32'h0, 32'h0, 32'hFFFFFFFF,
    32'h01234567, 32'hFFFFFFFF, 32'h1AF7C1E8, 32'h22222222, 32'h5A5A5A5A, 32'hFFFFFFFE};
  localparam logic [W-1:0] V_EXP [NV] = '{
    32'h1AF00CE8, 32'hFFFFFF80, 32'h12345678, 32'hA5A5A5A5, 32'h0, 32'hCAFEBABE, 32'h12345678,
    32'h0123BEEF, 32'h80000000, 32'hC56FC1B2, 32'h22221111, 32'h5A5A5A5A, 32'hFFFFFFFF};
  localparam string V_REQ [NV] = '{
    "R1", "R2", "R1", "R1", "R3", "R3", "R3", "R2", "R2", "R4", "R4", "R5", "R2"};

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [1:0] o,
                       input logic [W-1:0] d, input logic [W-1:0] s, input logic [W-1:0] m);
    @(negedge clk);
    in_valid = v; op = o; dst = d; src = s; msk = m;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; op = 2'b00; dst = '0; src = '0; msk = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    check("R8", res, '0);
    check("R8", {31'b0, out_valid}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(1'b1, V_OP[i], V_DST[i], V_SRC[i], V_MSK[i]);
      check(V_REQ[i], res, V_EXP[i]);
      check("R6", {31'b0, out_valid}, 32'd1);
    end

    // R7: idle cycle with changed inputs keeps result, R6: valid drops
    apply(1'b0, 2'b00, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    check("R7", res, 32'hFFFFFFFF);
    check("R6", {31'b0, out_valid}, 32'd0);
    apply(1'b0, 2'b10, 32'h13579BDF, 32'h0, 32'h0);
    check("R7", res, 32'hFFFFFFFF);

    // R1 then R8: reset after activity clears result
    apply(1'b1, 2'b00, 32'h0, 32'h0F0F0F0F, 32'h00FF00FF);
    check("R1", res, 32'h000F000F);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R8", res, '0);
    check("R8", {31'b0, out_valid}, 32'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule